// File: doc/BRIEF.md
# Key-protected slow clock source selector

This block produces the slow clock of a real-time-clock domain. It takes two clock sources: an external crystal clock and a free-running internal RC oscillator clock. The internal clock is divided by a fixed factor chosen when the block is built. It is then divided again by a programmable factor of one to thirty-two. A glitch-free multiplexer picks one of the two resulting clocks. A gated copy of the chosen clock goes to an output pin.

Software drives the block through a small synchronous register port. It has three registers. The control register selects the source, enables the external oscillator, and can turn off automatic fall-back. That register accepts a write only when the upper half of the write data carries an unlock key. The prescale register and the output-gate register need no key.

When fall-back is allowed and the selected external clock stops, a missing-clock detector in the internal-clock domain moves the selection to the internal source. Once edges return, the selection moves back to the external source.

Top module: `lsclk_sel`

## Requirements
- R1: A write to address 0 whose data bits [31:16] differ from 16'h16AA leaves the control register, the source in use and `ext_osc_en` unchanged.
- R2: A write to address 0 with bits [31:16] equal to 16'h16AA loads only three bits of the data: bit 0 (source, 1 = external), bit 4 (external oscillator enable) and bit 15 (fall-back off). All other bits are discarded.
- R3: `ext_osc_en` equals the stored control bit 4 from the clock cycle after an accepted write.
- R4: With control bit 15 set and the external source selected, a stopped external clock is not replaced, and `ls_clk` shows no rising edge while the external clock is stopped.
- R5: With control bit 0 clear, the `ls_clk` period is FIX_DIV × (P + 1) internal-clock periods. P is bits [4:0] of the prescale register at address 1, which is written without a key.
- R6: With control bit 0 set and the external clock running, the `ls_clk` period equals the external clock period.
- R7: A source switch never enables both sources at once. It never produces an `ls_clk` pulse shorter than the narrower half-period of the two sources.
- R8: With control bit 15 clear, when the external clock shows no edge for MISS_LIMIT internal-clock cycles, `ls_clk` moves to the divided internal clock. It returns to the external clock once edges resume.
- R9: Reads are combinational. Address 0 returns the control bits at positions 0, 4 and 15, with bits [31:16] reading as zero. Address 1 returns the prescale value zero-extended. Address 2 returns the gate bit in bit 0. Address 3 returns zero.
- R10: Bit 0 of the gate register at address 2 enables `ls_clk_out`. While it is clear, `ls_clk_out` stays low. While it is set, `ls_clk_out` has the same period as `ls_clk`.
- R11: After reset, all three registers read zero, `ext_osc_en` is low, `ls_clk_out` is low, and `ls_clk` runs from the divided internal clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst | input | 1 | Active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| int_osc_clk | input | 1 | Internal RC oscillator clock |
| ext_osc_clk | input | 1 | External crystal clock |
| ext_osc_en | output | 1 | Enable to the external oscillator |
| ls_clk | output | 1 | Selected slow clock |
| ls_clk_out | output | 1 | Gated copy of `ls_clk` for the pin |

## Verification
The bench checks the extreme prescale values 0 and 31:
- An off-by-one in the divider would show the internal period as 32 or 1024 cycles short or long.
- A truncated prescale field would wrap 31 to a smaller divide.

The bench sends wrong keys, including a write that carries a legal source change:
- A design that ignored the key would switch to the external clock.
- A design that mixed the key into the stored bits would read back nonzero upper bits.

Source changes run in both directions while the narrowest `ls_clk` pulse is tracked. A mux without the handshake would emit a sliver of one clock beside the other.

The bench stops the external clock twice, once with fall-back turned off and once with it allowed:
- A design that ignored the bypass would resume toggling.
- A design whose fall-back could not clear the dead side would freeze `ls_clk` instead of returning to the 640 ns internal period.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h16AA;

    localparam int SRC_BIT  = 0;
    localparam int OSC_BIT  = 4;
    localparam int BYP_BIT  = 15;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_PDIV = 2'd1,
        REG_GATE = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic fallback_off;
        logic osc_on;
        logic use_ext;
    } ctrl_t;

    function automatic logic key_ok(input logic [31:0] d);
        return d[31:16] == UNLOCK_KEY;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [31:0] d);
        ctrl_t c;
        c.fallback_off = d[BYP_BIT];
        c.osc_on       = d[OSC_BIT];
        c.use_ext      = d[SRC_BIT];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        logic [31:0] r;
        r          = '0;
        r[BYP_BIT] = c.fallback_off;
        r[OSC_BIT] = c.osc_on;
        r[SRC_BIT] = c.use_ext;
        return r;
    endfunction

endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
    import lsclk_pkg::*;
#(
    parameter int PDIV_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output ctrl_t             ctrl_q,
    output logic [PDIV_W-1:0] pdiv_q,
    output logic              gate_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pdiv_q <= '0;
            gate_q <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                REG_CTRL: if (key_ok(wdata)) ctrl_q <= unpack_ctrl(wdata);
                REG_PDIV: pdiv_q <= wdata[PDIV_W-1:0];
                REG_GATE: gate_q <= wdata[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL: rdata = pack_ctrl(ctrl_q);
            REG_PDIV: rdata = 32'(pdiv_q);
            REG_GATE: rdata = {31'd0, gate_q};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/lsclk_div.sv
module lsclk_div #(
    parameter int FIX_DIV = 32,
    parameter int PDIV_W  = 5
) (
    input  logic              osc_clk,
    input  logic              rst,
    input  logic [PDIV_W-1:0] pdiv,
    output logic              clk_o
);

    localparam int TOT_MAX = FIX_DIV * (1 << PDIV_W);
    localparam int CW      = $clog2(TOT_MAX + 1);

    logic [PDIV_W-1:0] p_s1, p_s2;
    logic [CW-1:0]     total, half, cnt, cnt_nx;
    logic              div_q;

    // prescale value is quasi-static; two flops bring it into this domain
    always_ff @(posedge osc_clk or posedge rst) begin
        if (rst) begin
            p_s1 <= '0;
            p_s2 <= '0;
        end else begin
            p_s1 <= pdiv;
            p_s2 <= p_s1;
        end
    end

    // fixed stage and programmable stage folded into one period count
    assign total  = CW'(FIX_DIV) * (CW'(p_s2) + CW'(1));
    assign half   = total >> 1;
    assign cnt_nx = (cnt >= total - CW'(1)) ? '0 : cnt + CW'(1);

    always_ff @(posedge osc_clk or posedge rst) begin
        if (rst) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            div_q <= (cnt_nx < half);
        end
    end

    generate
        if (FIX_DIV == 1) begin : g_passthru
            assign clk_o = (p_s2 == '0) ? osc_clk : div_q;
        end else begin : g_divided
            assign clk_o = div_q;
        end
    endgenerate

endmodule

// File: rtl/lsclk_miss.sv
module lsclk_miss #(
    parameter int MISS_LIMIT = 16
) (
    input  logic ref_clk,
    input  logic ext_clk,
    input  logic rst,
    output logic missing
);

    localparam int MW = $clog2(MISS_LIMIT + 1);

    logic          tog;
    logic [2:0]    tsync;
    logic [MW-1:0] idle;
    logic          seen;

    always_ff @(posedge ext_clk or posedge rst) begin
        if (rst) tog <= 1'b0;
        else     tog <= ~tog;
    end

    assign seen = tsync[2] ^ tsync[1];

    always_ff @(posedge ref_clk or posedge rst) begin
        if (rst) begin
            tsync   <= '0;
            idle    <= '0;
            missing <= 1'b0;
        end else begin
            tsync <= {tsync[1:0], tog};
            if (seen) begin
                idle    <= '0;
                missing <= 1'b0;
            end else if (idle == MW'(MISS_LIMIT - 1)) begin
                missing <= 1'b1;
            end else begin
                idle <= idle + MW'(1);
            end
        end
    end

endmodule

// File: rtl/lsclk_gfmux.sv
module lsclk_gfmux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_b,
    input  logic kill_b,
    output logic en_a,
    output logic en_b,
    output logic clk_o
);

    logic a_s1, a_s2, b_s1, b_s2;
    logic rst_b;

    assign rst_b = rst | kill_b;

    always_ff @(posedge clk_a or posedge rst) begin
        if (rst) begin
            a_s1 <= 1'b0;
            a_s2 <= 1'b0;
        end else begin
            a_s1 <= ~sel_b & ~en_b;
            a_s2 <= a_s1;
        end
    end

    always_ff @(negedge clk_a or posedge rst) begin
        if (rst) en_a <= 1'b0;
        else     en_a <= a_s2;
    end

    always_ff @(posedge clk_b or posedge rst_b) begin
        if (rst_b) begin
            b_s1 <= 1'b0;
            b_s2 <= 1'b0;
        end else begin
            b_s1 <= sel_b & ~en_a;
            b_s2 <= b_s1;
        end
    end

    always_ff @(negedge clk_b or posedge rst_b) begin
        if (rst_b) en_b <= 1'b0;
        else       en_b <= b_s2;
    end

    assign clk_o = (clk_a & en_a) | (clk_b & en_b);

endmodule

// File: rtl/lsclk_sel.sv
module lsclk_sel
    import lsclk_pkg::*;
#(
    parameter int FIX_DIV    = 32,
    parameter int PDIV_W     = 5,
    parameter int MISS_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        int_osc_clk,
    input  logic        ext_osc_clk,
    output logic        ext_osc_en,
    output logic        ls_clk,
    output logic        ls_clk_out
);

    ctrl_t             ctrl_q;
    logic [2:0]        ctl_word;
    logic [PDIV_W-1:0] pdiv_q;
    logic              gate_q;
    logic              int_div_clk;
    logic              missing;
    logic              force_int;
    logic              sel_ext;
    logic              int_on, ext_on;
    logic              g_s1, g_s2, g_on;

    lsclk_regs #(.PDIV_W(PDIV_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .ctrl_q (ctrl_q),
        .pdiv_q (pdiv_q),
        .gate_q (gate_q)
    );

    lsclk_div #(.FIX_DIV(FIX_DIV), .PDIV_W(PDIV_W)) u_div (
        .osc_clk (int_osc_clk),
        .rst     (rst),
        .pdiv    (pdiv_q),
        .clk_o   (int_div_clk)
    );

    lsclk_miss #(.MISS_LIMIT(MISS_LIMIT)) u_miss (
        .ref_clk (int_osc_clk),
        .ext_clk (ext_osc_clk),
        .rst     (rst),
        .missing (missing)
    );

    assign ctl_word   = ctrl_q;
    assign ext_osc_en = ctrl_q.osc_on;
    assign force_int  = missing & ~ctrl_q.fallback_off;
    assign sel_ext    = ctrl_q.use_ext & ~force_int;

    lsclk_gfmux u_mux (
        .clk_a  (int_div_clk),
        .clk_b  (ext_osc_clk),
        .rst    (rst),
        .sel_b  (sel_ext),
        .kill_b (force_int),
        .en_a   (int_on),
        .en_b   (ext_on),
        .clk_o  (ls_clk)
    );

    // output pin gate: enable retimed into the slow clock, applied while low
    always_ff @(posedge ls_clk or posedge rst) begin
        if (rst) begin
            g_s1 <= 1'b0;
            g_s2 <= 1'b0;
        end else begin
            g_s1 <= gate_q;
            g_s2 <= g_s1;
        end
    end

    always_ff @(negedge ls_clk or posedge rst) begin
        if (rst) g_on <= 1'b0;
        else     g_on <= g_s2;
    end

    assign ls_clk_out = ls_clk & g_on;

endmodule

// File: rtl/lsclk_sel_chk.sv
module lsclk_sel_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        ext_osc_en,
    input logic [2:0]  ctl_word,
    input logic        int_on,
    input logic        ext_on
);

    localparam logic [15:0] KEY = lsclk_pkg::UNLOCK_KEY;

    assert_badkey_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && wdata[31:16] != KEY) |=> $stable(ctl_word));

    assert_key_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && wdata[31:16] == KEY)
        |=> ctl_word == {$past(wdata[15]), $past(wdata[4]), $past(wdata[0])});

    assert_osc_enable_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && wdata[31:16] == KEY)
        |=> ext_osc_en == $past(wdata[4]));

    assert_one_source_R7: assert property (@(posedge clk) disable iff (rst)
        !(int_on && ext_on));

    assert_ctrl_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd0) |-> rdata[31:16] == 16'd0);

    assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd3) |-> rdata == 32'd0);

endmodule

bind lsclk_sel lsclk_sel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .ext_osc_en (ext_osc_en),
    .ctl_word   (ctl_word),
    .int_on     (int_on),
    .ext_on     (ext_on)
);

// File: tb/lsclk_sel_test.sv
`timescale 1ns/1ps
module lsclk_sel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        int_osc_clk = 1'b0;
    logic        ext_osc_clk = 1'b0;
    logic        ext_osc_en;
    logic        ls_clk;
    logic        ls_clk_out;

    bit  ext_run = 1'b1;
    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    int  cnt_ls = 0;
    int  cnt_out = 0;
    time last_edge = 0;
    time min_pulse = 0;
    bit  track_arm = 1'b0;

    localparam time INT_HALF = 10;
    localparam time EXT_HALF = 35;
    localparam int  FIXD     = 32;

    // {addr, wdata, expected read-back}
    localparam logic [65:0] VEC [10] = '{
        {2'd0, 32'h16AA_8000, 32'h0000_8000},
        {2'd0, 32'h16AB_0011, 32'h0000_8000},
        {2'd0, 32'h0000_0011, 32'h0000_8000},
        {2'd0, 32'h16AA_FFFE, 32'h0000_8010},
        {2'd1, 32'h0000_0023, 32'h0000_0003},
        {2'd1, 32'h1234_5660, 32'h0000_0000},
        {2'd2, 32'h0000_0003, 32'h0000_0001},
        {2'd2, 32'h0000_0000, 32'h0000_0000},
        {2'd3, 32'hFFFF_FFFF, 32'h0000_0000},
        {2'd0, 32'h16AA_0000, 32'h0000_0000}
    };

    lsclk_sel uut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .int_osc_clk (int_osc_clk),
        .ext_osc_clk (ext_osc_clk),
        .ext_osc_en  (ext_osc_en),
        .ls_clk      (ls_clk),
        .ls_clk_out  (ls_clk_out)
    );

    always #2.5 clk = ~clk;
    always #(INT_HALF) int_osc_clk = ~int_osc_clk;
    always begin
        #(EXT_HALF);
        if (ext_run) ext_osc_clk = ~ext_osc_clk;
    end

    always @(posedge ls_clk) cnt_ls++;
    always @(posedge ls_clk_out) cnt_out++;

    always @(ls_clk) begin
        if (track_arm) begin
            if ($time - last_edge < min_pulse) min_pulse = $time - last_edge;
        end
        last_edge = $time;
        track_arm = 1'b1;
    end

    task automatic arm_tracker();
        track_arm = 1'b0;
        min_pulse = 1000000;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_min(input string req, input longint act, input longint lim);
        total++;
        if (act < lim) begin
            bad++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic period_ls(output longint p);
        time t0;
        @(posedge ls_clk);
        t0 = $time;
        @(posedge ls_clk);
        p = longint'($time - t0);
    endtask

    task automatic period_out(output longint p);
        time t0;
        @(posedge ls_clk_out);
        t0 = $time;
        @(posedge ls_clk_out);
        p = longint'($time - t0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        longint      p;

        repeat (20) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        bus_read(2'd0, rd); check("R11 ctrl after reset", rd, 0);
        bus_read(2'd1, rd); check("R11 prescale after reset", rd, 0);
        bus_read(2'd2, rd); check("R11 gate after reset", rd, 0);
        check("R11 ext_osc_en after reset", ext_osc_en, 0);
        check("R11 ls_clk_out after reset", ls_clk_out, 0);

        // R1 R2 R9 register table
        for (int i = 0; i < 10; i++) begin
            bus_write(VEC[i][65:64], VEC[i][63:32]);
            bus_read(VEC[i][65:64], rd);
            check($sformatf("R2/R1/R9 vector %0d", i), rd, VEC[i][31:0]);
            if (i == 3) check("R3 osc enable set", ext_osc_en, 1);
        end
        check("R3 osc enable cleared", ext_osc_en, 0);

        // R11 R5: internal source, prescale 0
        #2000;
        period_ls(p); check("R11 R5 internal period p=0", p, FIXD * 20);

        // R10: gate off, then on
        #1000;
        cnt_out = 0;
        #2000;
        check("R10 gated pin idle", cnt_out, 0);
        bus_write(2'd2, 32'd1);
        #3000;
        period_out(p); check("R10 pin period", p, FIXD * 20);

        // R5: prescale 3 and maximum 31
        bus_write(2'd1, 32'd3);
        #5000;
        period_ls(p); check("R5 internal period p=3", p, FIXD * 4 * 20);
        bus_write(2'd1, 32'd31);
        #45000;
        period_ls(p); check("R5 internal period p=31", p, FIXD * 32 * 20);
        bus_write(2'd1, 32'd0);
        #3000;

        // R6 R3 R7: switch to external
        arm_tracker();
        bus_write(2'd0, 32'h16AA_0011);
        #3000;
        period_ls(p); check("R6 external period", p, 2 * EXT_HALF);
        check("R3 osc enable with external", ext_osc_en, 1);
        check_min("R7 narrowest pulse to external", min_pulse, EXT_HALF);

        // R7: back to internal
        arm_tracker();
        bus_write(2'd0, 32'h16AA_0010);
        #4000;
        period_ls(p); check("R7 internal period after switch", p, FIXD * 20);
        check_min("R7 narrowest pulse to internal", min_pulse, EXT_HALF);

        // R1: wrong key carrying a source change while running
        bus_write(2'd0, 32'h5555_0011);
        #3000;
        period_ls(p); check("R1 source unchanged by bad key", p, FIXD * 20);
        bus_read(2'd0, rd); check("R1 ctrl unchanged by bad key", rd, 32'h10);

        // R4: fall-back off, external stops
        bus_write(2'd0, 32'h16AA_8011);
        #3000;
        period_ls(p); check("R4 external period before stop", p, 2 * EXT_HALF);
        ext_run = 1'b0;
        #1000;
        cnt_ls = 0;
        #5000;
        check("R4 no fall-back when bypassed", cnt_ls, 0);

        // R8: fall-back allowed, then recovery
        bus_write(2'd0, 32'h16AA_0011);
        #4000;
        period_ls(p); check("R8 fall-back to internal", p, FIXD * 20);
        ext_run = 1'b1;
        #4000;
        period_ls(p); check("R8 return to external", p, 2 * EXT_HALF);

        finish_run();
    end

endmodule